// File: doc/BRIEF.md
# Bidirectional BCD Decade Counter with Parallel Load

This block is a single synchronous decimal digit. On each rising clock edge it steps through 0 to 9, either upward or downward as a direction pin selects. A synchronous parallel load can preset it to any 4-bit value. An active-low count enable freezes it. A terminal-count flag goes high at 9 when counting up and at 0 when counting down. An active-low ripple-clock pulse is the enable a neighbouring digit would use.

The next value comes from a per-bit toggle network rather than an adder. The least significant bit flips on every count. Each higher bit flips when the bits below it are all ones (counting up) or all zeros (counting down). Two extra terms make the sequence wrap at ten, and they also decide how the counter returns to decimal after a value from 10 to 15 has been loaded. All pins are plain control and status pins; there is no streaming interface and so no back-pressure.

Top module: `updn_decade_ctr`

## Requirements
- R1: While rst_n is low the count is 0; reset is asynchronous and active low.
- R2: With cnt_dn=0, ld=0 and cnt_en_n=0, each rising edge raises the count by one from 0 through 9, and 9 is followed by 0.
- R3: With cnt_dn=1, ld=0 and cnt_en_n=0, each rising edge lowers the count by one, and 0 is followed by 9.
- R4: With ld=0 and cnt_en_n=1, the count holds its value across rising edges.
- R5: When ld=1 at a rising edge, the count takes the value of ld_val whatever cnt_en_n and cnt_dn are. Load takes priority over counting and over the hold.
- R6: tc_flag is 1 exactly when (cnt_dn=0 and the count is 9) or (cnt_dn=1 and the count is 0). It follows the count and the direction combinationally.
- R7: rip_clk_n is 0 only while clk is low, tc_flag is 1 and cnt_en_n is 0; otherwise it is 1.
- R8: Counting up from a loaded non-decimal value returns to 0..9 within two counts: 10 goes to 11 then 6, 12 goes to 13 then 4, and 14 goes to 15 then 2.
- R9: Counting down from a loaded value between 10 and 15 lowers it by one per count until it reaches 9.
- R10: Once the count is between 0 and 9, counting in either direction or holding never leaves that range; only a load can do so.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the count |
| cnt_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| cnt_en_n | input | 1 | Count enable, active low; 1 holds the count |
| ld | input | 1 | Synchronous parallel load, active high |
| ld_val | input | 4 | Value taken on a load |
| bcd_q | output | 4 | Current count |
| tc_flag | output | 1 | Terminal count for the present direction |
| rip_clk_n | output | 1 | Active-low ripple clock for chaining |

## Verification
On every cycle the assertions check the hold, the load priority, the two wrap points and the rule that a decimal count stays decimal. The bench's scenarios are needed for the exact step-by-step sequences. These are the full up and down runs, the recovery paths from the six non-decimal values, and the decrement from values above 9. The bench also checks the terminal flag under both directions and the low-half-cycle shape of the ripple clock, which depends on the clock level rather than on an edge.

// File: rtl/updn_dec_pkg.sv
package updn_dec_pkg;
  localparam int DIG_W   = 4;
  localparam int DIG_TOP = 9;
  typedef logic [DIG_W-1:0] digit_t;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/dec_toggle_net.sv
module dec_toggle_net
  import updn_dec_pkg::*;
(
  input  digit_t cur,
  input  logic   dn,
  output digit_t nxt
);
  logic   is_zero;
  digit_t tog;

  assign is_zero = (cur == '0);

  genvar i;
  generate
    for (i = 0; i < DIG_W; i++) begin : g_bit
      logic t_up, t_dn;
      if (i == 0) begin : g_lsb
        assign t_up = 1'b1;
        assign t_dn = 1'b1;
      end else if (i == 1) begin : g_b1
        // up: blocked at 9 so the wrap does not set bit 1
        assign t_up = cur[0] & ~cur[DIG_W-1];
        assign t_dn = ~cur[0] & ~is_zero;
      end else if (i == DIG_W - 1) begin : g_msb
        // up: also flips when leaving 9 (or 11/13/15); down: flips on 0 -> 9
        assign t_up = (&cur[i-1:0]) | (cur[0] & cur[DIG_W-1]);
        assign t_dn = (~|cur[i-1:0] & ~is_zero) | is_zero;
      end else begin : g_mid
        assign t_up = &cur[i-1:0];
        assign t_dn = ~|cur[i-1:0] & ~is_zero;
      end
      assign tog[i] = dn ? t_dn : t_up;
    end
  endgenerate

  assign nxt = cur ^ tog;
endmodule

// File: rtl/dec_term_det.sv
module dec_term_det
  import updn_dec_pkg::*;
(
  input  digit_t cur,
  input  logic   dn,
  output logic   term
);
  localparam digit_t TOP_VAL = digit_t'(DIG_TOP);
  assign term = dn ? (cur == '0) : (cur == TOP_VAL);
endmodule

// File: rtl/dec_rclk_gen.sv
module dec_rclk_gen (
  input  logic clk,
  input  logic term,
  input  logic en_n,
  output logic rclk_n
);
  assign rclk_n = ~(term & ~en_n & ~clk);
endmodule

// File: rtl/updn_decade_ctr.sv
module updn_decade_ctr
  import updn_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_dn,
  input  logic             cnt_en_n,
  input  logic             ld,
  input  logic [DIG_W-1:0] ld_val,
  output logic [DIG_W-1:0] bcd_q,
  output logic             tc_flag,
  output logic             rip_clk_n
);
  localparam digit_t TOP_VAL = digit_t'(DIG_TOP);
  localparam digit_t LIM_VAL = digit_t'(DIG_TOP + 1);

  digit_t cnt_r, step_v;

  dec_toggle_net u_tog (.cur(cnt_r), .dn(cnt_dn), .nxt(step_v));
  dec_term_det   u_tc  (.cur(cnt_r), .dn(cnt_dn), .term(tc_flag));
  dec_rclk_gen   u_rc  (.clk(clk), .term(tc_flag), .en_n(cnt_en_n), .rclk_n(rip_clk_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_r <= '0;
    else if (ld)       cnt_r <= ld_val;
    else if (!cnt_en_n) cnt_r <= step_v;
  end

  assign bcd_q = cnt_r;

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_en_n) |=> $stable(bcd_q));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (bcd_q == $past(ld_val)));

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !cnt_en_n && !cnt_dn && bcd_q == TOP_VAL) |=> (bcd_q == '0));

  // R3
  dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !cnt_en_n && cnt_dn && bcd_q == '0) |=> (bcd_q == TOP_VAL));

  // R10
  dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && bcd_q < LIM_VAL) |=> (bcd_q < LIM_VAL));
endmodule

// File: tb/sim_updn_decade_ctr.sv
module sim_updn_decade_ctr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_dn = 1'b0, cnt_en_n = 1'b1, ld = 1'b0;
  logic [3:0] ld_val = 4'd0;
  logic [3:0] bcd_q;
  logic       tc_flag, rip_clk_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] model = 4'd0;
  logic [3:0] exp_q[$];
  string      exp_tag[$];

  always #2 clk = ~clk;

  updn_decade_ctr u0 (.clk(clk), .rst_n(rst_n), .cnt_dn(cnt_dn), .cnt_en_n(cnt_en_n),
    .ld(ld), .ld_val(ld_val), .bcd_q(bcd_q), .tc_flag(tc_flag), .rip_clk_n(rip_clk_n));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] next_of(logic [3:0] m, logic l, logic [3:0] d, logic en_n, logic dn);
    if (l) return d;
    if (en_n) return m;
    if (!dn) begin
      case (m)
        4'd9:  return 4'd0;
        4'd11: return 4'd6;
        4'd13: return 4'd4;
        4'd15: return 4'd2;
        default: return m + 4'd1;
      endcase
    end
    return (m == 4'd0) ? 4'd9 : m - 4'd1;
  endfunction

  // driver: sets inputs in the low half, checks flag/ripple there, pushes expected count
  task automatic drive(input logic l, input logic [3:0] d, input logic en_n, input logic dn, input string tag);
    logic tc_e;
    @(negedge clk);
    ld = l; ld_val = d; cnt_en_n = en_n; cnt_dn = dn;
    #1;
    tc_e = dn ? (model == 4'd0) : (model == 4'd9);
    check({tag, " R6 tc_flag"}, {3'b0, tc_flag}, {3'b0, tc_e});
    check({tag, " R7 rip_clk_n low half"}, {3'b0, rip_clk_n}, {3'b0, ~(tc_e & ~en_n)});
    model = next_of(model, l, d, en_n, dn);
    exp_q.push_back(model);
    exp_tag.push_back(tag);
  endtask

  // monitor: pops expected counts after each edge; also checks ripple in high half
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check({t, " count"}, bcd_q, e);
        check({t, " R7 rip_clk_n high half"}, {3'b0, rip_clk_n}, 4'd1);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", bcd_q, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 up through 9 and wrap
    for (int k = 0; k < 12; k++) drive(1'b0, 4'd0, 1'b0, 1'b0, "R2 up");
    // R5 load 9 while disabled, then R4 hold with flag high
    drive(1'b1, 4'd9, 1'b1, 1'b0, "R5 load when disabled");
    for (int k = 0; k < 3; k++) drive(1'b0, 4'd0, 1'b1, 1'b0, "R4 hold");
    // R5 load beats counting
    drive(1'b1, 4'd3, 1'b0, 1'b0, "R5 load over count");
    // R3 down with wrap from 0 to 9
    for (int k = 0; k < 12; k++) drive(1'b0, 4'd0, 1'b0, 1'b1, "R3 down");
    drive(1'b0, 4'd0, 1'b1, 1'b1, "R4 hold down");
    // R8 recovery from non-decimal loads, counting up
    for (int v = 10; v <= 15; v += 2) begin
      drive(1'b1, 4'(v), 1'b0, 1'b0, "R8 load");
      drive(1'b0, 4'd0, 1'b0, 1'b0, "R8 step1");
      drive(1'b0, 4'd0, 1'b0, 1'b0, "R8 step2");
    end
    // R8 direct from odd codes
    drive(1'b1, 4'd11, 1'b0, 1'b0, "R8 load11");
    drive(1'b0, 4'd0, 1'b0, 1'b0, "R8 from11");
    // R9 down from 15 to 9
    drive(1'b1, 4'd15, 1'b0, 1'b1, "R9 load15");
    for (int k = 0; k < 8; k++) drive(1'b0, 4'd0, 1'b0, 1'b1, "R9 down");
    // R10 long mixed run stays decimal
    for (int k = 0; k < 25; k++) drive(1'b0, 4'd0, 1'b0, k[2], "R10 mixed");
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule